// File: doc/BRIEF.md
# Mode-Selectable Extended Address Generator

This block forms the 24-bit external memory address of an 8-bit microcontroller core that can run in three address modes. Each access names its type: a move through either of two data pointers, a move through an 8-bit indirect register, an instruction fetch, a stack access or an interrupt vector fetch. The low sixteen bits come from the pointer that belongs to that access type. The upper byte comes from a per-type extension register, from the program counter or from zero, depending on the active mode.

A 2-bit mode register is written by the core and comes out of reset in 16-bit mode. The address is registered, so it is valid one cycle after the request. Address bit 22 selects the 4 kB internal SRAM window that sits above the 4 MB external space, and a separate output flags it.

Top module: `xag_addr_gen`

## Requirements
- R1: The mode register holds 2'b00 = 16-bit, 2'b01 = 22-bit paged or 2'b10 = 22-bit contiguous. A write with `mode_we` high takes effect for requests from the next cycle on. A request in the same cycle as the write still uses the old mode, and without a write the mode never changes.
- R2: After reset the mode is 16-bit and `addr_valid`, `addr_out` and `sram_sel` are all 0.
- R3: In 16-bit mode, and in the unused encoding 2'b11, which behaves as 16-bit, bits 23:16 of every address are zero. The low 16 bits follow the same rules as in the other modes.
- R4: Data sources in the two 22-bit modes: `req_src` 0 gives {`dpx0`, `dptr0`}, `req_src` 1 gives {`dpx1`, `dptr1`} and `req_src` 2 gives {`mxext`, `p2`, `ri`}. In 16-bit mode the low 16 bits are `dptr0`, `dptr1` or {`p2`, `ri`}.
- R5: Fetch (`req_src` 3) gives {8'h00, `pc[15:0]`} in 16-bit mode, {`apage`, `pc[15:0]`} in paged mode and {2'b00, `pc[21:0]`} in contiguous mode.
- R6: Vector fetch (`req_src` 5) gives {16'h0000, `vec_lo`} in every mode.
- R7: Stack (`req_src` 4) gives {8'h00, `esp`, `sp`} when `stack10_en` is 1 and {16'h0000, `sp`} when it is 0, in every mode.
- R8: `sram_sel` equals address bit 22 of a valid output address and is 0 when `addr_valid` is 0.
- R9: A request that is accepted in cycle n has its outputs valid in cycle n+1. Without a request, `addr_valid` is 0 and `addr_out` is 0 in the next cycle.
- R10: The unused source codes 6 and 7 produce a valid address of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_we | input | 1 | Mode register write strobe |
| mode_wdata | input | 2 | New mode value |
| stack10_en | input | 1 | Extended (10-bit) stack pointer enable |
| req_valid | input | 1 | Access request |
| req_src | input | 3 | Access type code |
| dptr0 | input | 16 | First data pointer |
| dptr1 | input | 16 | Second data pointer |
| ri | input | 8 | Indirect register |
| p2 | input | 8 | High byte for indirect moves |
| pc | input | 22 | Program counter |
| sp | input | 8 | Stack pointer |
| vec_lo | input | 8 | Interrupt vector offset |
| dpx0 | input | 8 | Extension byte for the first data pointer |
| dpx1 | input | 8 | Extension byte for the second data pointer |
| mxext | input | 8 | Extension byte for indirect moves |
| apage | input | 8 | Program page byte for paged mode |
| esp | input | 8 | Stack pointer high byte |
| addr_valid | output | 1 | Output address valid |
| addr_out | output | 24 | Generated address |
| sram_sel | output | 1 | Internal SRAM window select |

## Verification
A mode-register write and an access request can land in the same cycle. That access must use the old mode, and the access in the cycle after it must use the new one. The bench makes this happen with directed writes that carry a fetch and a data request in the same cycle, and with random stimulus in which about one cycle in eight writes the mode. A behavioural model in the bench moves its own mode variable only after it has computed that cycle's expected address, and it compares every output on every clock.

// File: rtl/xag_pkg.sv
package xag_pkg;
    localparam int XA_BYTE_W  = 8;
    localparam int XA_PTR_W   = 16;
    localparam int XA_PC_W    = 22;
    localparam int XA_MODE_W  = 2;
    localparam int XA_SRC_W   = 3;
    localparam int XA_ADDR_W  = XA_PTR_W + XA_BYTE_W;
    localparam int XA_SRAM_BIT = XA_PC_W;
    localparam int XA_PC_HI_W = XA_PC_W - XA_PTR_W;

    typedef enum logic [XA_MODE_W-1:0] {
        MODE_NARROW = 2'b00,
        MODE_PAGED  = 2'b01,
        MODE_FLAT   = 2'b10,
        MODE_RSVD   = 2'b11
    } xmode_e;

    typedef enum logic [XA_SRC_W-1:0] {
        SRC_DP0   = 3'd0,
        SRC_DP1   = 3'd1,
        SRC_IND   = 3'd2,
        SRC_FETCH = 3'd3,
        SRC_STACK = 3'd4,
        SRC_VEC   = 3'd5,
        SRC_NONE6 = 3'd6,
        SRC_NONE7 = 3'd7
    } xsrc_e;

    typedef struct packed {
        logic [XA_PTR_W-1:0]  dp0;
        logic [XA_PTR_W-1:0]  dp1;
        logic [XA_BYTE_W-1:0] ind;
        logic [XA_BYTE_W-1:0] ind_hi;
        logic [XA_PC_W-1:0]   pc;
        logic [XA_BYTE_W-1:0] sp;
        logic [XA_BYTE_W-1:0] vec;
    } xptr_t;

    typedef struct packed {
        logic [XA_BYTE_W-1:0] dp0_x;
        logic [XA_BYTE_W-1:0] dp1_x;
        logic [XA_BYTE_W-1:0] ind_x;
        logic [XA_BYTE_W-1:0] page;
        logic [XA_BYTE_W-1:0] sp_x;
    } xext_t;

    typedef struct packed {
        logic wide;
        logic paged;
        logic flat;
    } xmdec_t;

    function automatic xmdec_t decode_mode(input xmode_e m);
        xmdec_t d;
        d.paged = (m == MODE_PAGED);
        d.flat  = (m == MODE_FLAT);
        d.wide  = d.paged | d.flat;
        return d;
    endfunction
endpackage

// File: rtl/xag_mode_ctl.sv
module xag_mode_ctl
    import xag_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we,
    input  logic [XA_MODE_W-1:0] wdata,
    output xmode_e               mode_q,
    output xmdec_t               mdec
);
    always_ff @(posedge clk) begin
        if (rst)
            mode_q <= MODE_NARROW;
        else if (we)
            mode_q <= xmode_e'(wdata);
    end

    assign mdec = decode_mode(mode_q);

    AST_MODE_RESET: assert property (@(posedge clk) rst |=> (mode_q == MODE_NARROW)); // R2
    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(mode_q)); // R1
    AST_MODE_LOAD: assert property (@(posedge clk) disable iff (rst)
        we |=> (mode_q == $past(wdata))); // R1
endmodule

// File: rtl/xag_low_sel.sv
module xag_low_sel
    import xag_pkg::*;
(
    input  xsrc_e               src,
    input  xptr_t               ptr,
    input  logic [XA_BYTE_W-1:0] sp_x,
    input  logic                stack10,
    output logic [XA_PTR_W-1:0] low
);
    localparam int HB = XA_PTR_W - XA_BYTE_W;

    always_comb begin
        low = '0;
        unique case (src)
            SRC_DP0:   low = ptr.dp0;
            SRC_DP1:   low = ptr.dp1;
            SRC_IND:   low = {ptr.ind_hi, ptr.ind};
            SRC_FETCH: low = ptr.pc[XA_PTR_W-1:0];
            SRC_STACK: low = {(stack10 ? sp_x : {HB{1'b0}}), ptr.sp};
            SRC_VEC:   low = {{HB{1'b0}}, ptr.vec};
            default:   low = '0;
        endcase
    end
endmodule

// File: rtl/xag_high_sel.sv
module xag_high_sel
    import xag_pkg::*;
(
    input  xsrc_e                   src,
    input  xmdec_t                  mdec,
    input  xext_t                   ext,
    input  logic [XA_PC_HI_W-1:0]   pc_hi,
    output logic [XA_BYTE_W-1:0]    high
);
    localparam int PAD = XA_BYTE_W - XA_PC_HI_W;

    always_comb begin
        high = '0;
        if (mdec.wide) begin
            unique case (src)
                SRC_DP0:   high = ext.dp0_x;
                SRC_DP1:   high = ext.dp1_x;
                SRC_IND:   high = ext.ind_x;
                SRC_FETCH: high = mdec.flat ? {{PAD{1'b0}}, pc_hi} : ext.page;
                default:   high = '0;
            endcase
        end
    end
endmodule

// File: rtl/xag_addr_gen.sv
module xag_addr_gen
    import xag_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 mode_we,
    input  logic [1:0]           mode_wdata,
    input  logic                 stack10_en,
    input  logic                 req_valid,
    input  logic [2:0]           req_src,
    input  logic [15:0]          dptr0,
    input  logic [15:0]          dptr1,
    input  logic [7:0]           ri,
    input  logic [7:0]           p2,
    input  logic [21:0]          pc,
    input  logic [7:0]           sp,
    input  logic [7:0]           vec_lo,
    input  logic [7:0]           dpx0,
    input  logic [7:0]           dpx1,
    input  logic [7:0]           mxext,
    input  logic [7:0]           apage,
    input  logic [7:0]           esp,
    output logic                 addr_valid,
    output logic [23:0]          addr_out,
    output logic                 sram_sel
);
    xmode_e                 mode_q;
    xmdec_t                 mdec;
    xptr_t                  ptr;
    xext_t                  ext;
    xsrc_e                  src;
    logic [XA_PTR_W-1:0]    low;
    logic [XA_BYTE_W-1:0]   high;
    logic [XA_ADDR_W-1:0]   nxt;
    logic                   wide_q;

    assign src = xsrc_e'(req_src);
    assign ptr = '{dp0: dptr0, dp1: dptr1, ind: ri, ind_hi: p2, pc: pc, sp: sp, vec: vec_lo};
    assign ext = '{dp0_x: dpx0, dp1_x: dpx1, ind_x: mxext, page: apage, sp_x: esp};

    xag_mode_ctl i_mode (
        .clk(clk), .rst(rst), .we(mode_we), .wdata(mode_wdata),
        .mode_q(mode_q), .mdec(mdec)
    );

    xag_low_sel i_low (
        .src(src), .ptr(ptr), .sp_x(esp), .stack10(stack10_en), .low(low)
    );

    xag_high_sel i_high (
        .src(src), .mdec(mdec), .ext(ext),
        .pc_hi(pc[XA_PC_W-1:XA_PTR_W]), .high(high)
    );

    assign nxt = {high, low};

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_valid <= 1'b0;
            addr_out   <= '0;
            sram_sel   <= 1'b0;
            wide_q     <= 1'b0;
        end else begin
            addr_valid <= req_valid;
            addr_out   <= req_valid ? nxt : '0;
            sram_sel   <= req_valid & nxt[XA_SRAM_BIT];
            wide_q     <= mdec.wide;
        end
    end

    AST_NARROW_HI_ZERO: assert property (@(posedge clk) disable iff (rst)
        (addr_valid && !wide_q) |-> (addr_out[23:16] == 8'h00)); // R3
    AST_REQ_LATENCY: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> addr_valid); // R9
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!addr_valid && addr_out == '0)); // R9
    AST_SRAM_FLAG: assert property (@(posedge clk) disable iff (rst)
        sram_sel |-> (addr_valid && addr_out[XA_SRAM_BIT])); // R8
    AST_SRAM_MISS: assert property (@(posedge clk) disable iff (rst)
        (addr_valid && !addr_out[XA_SRAM_BIT]) |-> !sram_sel); // R8
    AST_VEC_PAGE0: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_src == 3'd5) |=> (addr_out[23:8] == 16'h0000)); // R6
    AST_FLAT_FETCH_TOP: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_src == 3'd3 && mode_q == MODE_FLAT && !mode_we)
        |=> (addr_out[23:22] == 2'b00)); // R5
    AST_UNUSED_SRC: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_src[2:1] == 2'b11) |=> (addr_out == '0)); // R10
endmodule

// File: tb/test_xag_addr_gen.sv
module test_xag_addr_gen;
    logic        clk = 1'b0;
    logic        rst;
    logic        mode_we;
    logic [1:0]  mode_wdata;
    logic        stack10_en;
    logic        req_valid;
    logic [2:0]  req_src;
    logic [15:0] dptr0, dptr1;
    logic [7:0]  ri, p2, sp, vec_lo, dpx0, dpx1, mxext, apage, esp;
    logic [21:0] pc;
    logic        addr_valid, sram_sel;
    logic [23:0] addr_out;

    int tests = 0;
    int fails = 0;
    int mmode = 0;
    logic        e_valid, e_sram;
    logic [23:0] e_addr;
    bit done = 0;

    always #2 clk = ~clk;

    xag_addr_gen i_xag_addr_gen (
        .clk(clk), .rst(rst), .mode_we(mode_we), .mode_wdata(mode_wdata),
        .stack10_en(stack10_en), .req_valid(req_valid), .req_src(req_src),
        .dptr0(dptr0), .dptr1(dptr1), .ri(ri), .p2(p2), .pc(pc), .sp(sp),
        .vec_lo(vec_lo), .dpx0(dpx0), .dpx1(dpx1), .mxext(mxext),
        .apage(apage), .esp(esp), .addr_valid(addr_valid),
        .addr_out(addr_out), .sram_sel(sram_sel)
    );

    function automatic logic [23:0] model(input int m, input int s);
        int wide = (m == 1 || m == 2);
        longint a = 0;
        case (s)
            0: a = (wide ? dpx0 * 65536 : 0) + dptr0;
            1: a = (wide ? dpx1 * 65536 : 0) + dptr1;
            2: a = (wide ? mxext * 65536 : 0) + p2 * 256 + ri;
            3: a = (m == 2) ? pc : ((m == 1) ? apage * 65536 : 0) + (pc % 65536);
            4: a = (stack10_en ? esp * 256 : 0) + sp;
            5: a = vec_lo;
            default: a = 0;
        endcase
        return a[23:0];
    endfunction

    function automatic string tag(input int s);
        case (s)
            0, 1, 2: return "R4";
            3: return "R5";
            4: return "R7";
            5: return "R6";
            default: return "R10";
        endcase
    endfunction

    task automatic check(input string req);
        tests++;
        if (addr_valid !== e_valid || addr_out !== e_addr || sram_sel !== e_sram) begin
            fails++;
            $display("FAIL %s: valid/addr/sram = %0b/%06h/%0b expected %0b/%06h/%0b",
                     req, addr_valid, addr_out, sram_sel, e_valid, e_addr, e_sram);
        end
    endtask

    // one clock: model samples inputs at the edge, check at the following negedge
    task automatic cyc(input string req);
        @(posedge clk);
        if (rst) begin
            e_valid = 0; e_addr = 0; e_sram = 0; mmode = 0;
        end else begin
            e_valid = req_valid;
            e_addr  = req_valid ? model(mmode, req_src) : 24'h0;
            e_sram  = req_valid && e_addr[22];
            if (mode_we) mmode = mode_wdata;
        end
        @(negedge clk);
        check(req);
    endtask

    task automatic set_ptrs();
        dptr0 = $urandom; dptr1 = $urandom; ri = $urandom; p2 = $urandom;
        pc = $urandom; sp = $urandom; vec_lo = $urandom; dpx0 = $urandom;
        dpx1 = $urandom; mxext = $urandom; apage = $urandom; esp = $urandom;
        stack10_en = $urandom;
    endtask

    task automatic req(input int s, input string r);
        req_valid = 1; req_src = s[2:0];
        cyc(r);
        req_valid = 0; mode_we = 0;
    endtask

    task automatic setmode(input int m);
        mode_we = 1; mode_wdata = m[1:0]; req_valid = 0;
        cyc("R1");
        mode_we = 0;
    endtask

    initial begin
        rst = 1; mode_we = 0; mode_wdata = 0; req_valid = 0; req_src = 0;
        set_ptrs();
        @(negedge clk);
        cyc("R2"); cyc("R2");
        rst = 0;
        // reset mode is 16-bit: fetch with a nonzero page byte keeps upper zero
        apage = 8'hC5; pc = 22'h3F_1234;
        req(3, "R2");
        // R3 unused mode 2'b11 acts as 16-bit
        setmode(3);
        dpx0 = 8'h7E; req(0, "R3");
        pc = 22'h2A_BCDE; apage = 8'h41; req(3, "R3");
        // R5 paged fetch, SRAM bit via page byte (R8)
        setmode(1);
        req(3, "R5");
        apage = 8'h40; req(3, "R8");
        // R5 contiguous fetch with top PC bits set
        setmode(2);
        pc = 22'h3F_FFFF; req(3, "R5");
        // R4 data sources in wide mode, SRAM window via extension byte
        dpx1 = 8'h40; req(1, "R8");
        req(0, "R4"); req(2, "R4");
        // R6 vectors in every mode, R7 stack in both stack widths
        for (int m = 0; m < 4; m++) begin
            setmode(m);
            vec_lo = 8'h23 + m[7:0]; req(5, "R6");
            stack10_en = 1; esp = 8'h03; req(4, "R7");
            stack10_en = 0; req(4, "R7");
        end
        // R10 unused source codes
        req(6, "R10"); req(7, "R10");
        // R1 mode write and request in the same cycle: old mode used, then new
        setmode(0);
        mode_we = 1; mode_wdata = 2'b10; pc = 22'h35_0001; req(3, "R1");
        req(3, "R1");
        mode_we = 1; mode_wdata = 2'b00; dpx0 = 8'h55; req(0, "R1");
        req(0, "R1");
        // R9 idle cycle after requests
        cyc("R9");
        // random traffic
        for (int i = 0; i < 3000; i++) begin
            set_ptrs();
            req_valid = ($urandom % 5) != 0;
            req_src = $urandom;
            mode_we = ($urandom % 8) == 0;
            mode_wdata = $urandom;
            cyc(req_valid ? tag(req_src) : "R9");
        end
        mode_we = 0; req_valid = 0;
        // reset in mid-run returns to 16-bit mode
        setmode(2);
        rst = 1; req_valid = 1; req_src = 3; cyc("R2");
        rst = 0; apage = 8'h99; req(3, "R2");
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: run did not finish, got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule